// File: doc/BRIEF.md
# Self-ID Complement Pair Checker

This block watches the self-identification quadlets that a serial-bus link receives after power-up or after a bus reset. Each self-ID unit arrives as two 32-bit quadlets, and the second one is only valid if it is the exact bitwise inverse of the first. The block pairs the incoming quadlets, compares every second quadlet against the inverse of the one before it, and records mismatches in a sticky status register. Software clears that register by writing ones. It also flags a packet that ends halfway through a pair.

A single-cycle interrupt pulse marks the end of any packet in which an error was found. A free-running count of completed pairs lets software confirm how many self-ID units went past. A software enable bit switches the check off. While the check is off, quadlets are still paired and counted, but no error is recorded and no interrupt is raised. A bus-reset strobe restarts the pairing and the pair count, so the self-ID sequence that follows is checked from a clean state.

Top module: `selfid_pair_chk`

## Requirements
- R1: After the synchronous reset, `err_status` is 0, `irq` is 0 and `pair_cnt` is 0.
- R2: Quadlets accepted with `q_valid` alternate between first and second of a pair. Every second quadlet increments `pair_cnt` by one (wrapping at its width), and the new count is visible the cycle after that quadlet. This happens whether or not the check is enabled.
- R3: With `chk_en` high, a second quadlet that is not the bitwise inverse of the first sets `err_status` bit 0 (mismatch) in the following cycle.
- R4: A second quadlet equal to the bitwise inverse of the first sets no status bit and raises no interrupt.
- R5: With `chk_en` high, a quadlet carrying `q_last` that is a first quadlet (the packet held an odd count) sets `err_status` bit 1 (incomplete pair). The quadlet after any `q_last` is always treated as a first quadlet.
- R6: `irq` is high for exactly one cycle, the cycle after the `q_last` quadlet of a packet in which at least one error was detected with `chk_en` high. There is one pulse per packet, however many errors it held.
- R7: Status bits stay set until a 1 is written to the matching bit of `status_clr`. Clearing one bit leaves the other untouched. A new error in the same cycle as its clear leaves the bit set.
- R8: While `chk_en` is low, no status bit becomes set and `irq` stays low.
- R9: `bus_rst` clears `pair_cnt` and the pair phase, and any quadlet presented in the same cycle is discarded. The status register keeps its value across `bus_rst`.
- R10: Cycles with `q_valid` low have no effect. Idle gaps inside a pair do not change pairing or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst | input | 1 | Bus-reset strobe, restarts pairing and count |
| chk_en | input | 1 | Enables the complement check |
| q_valid | input | 1 | Quadlet strobe |
| q_data | input | DW (32) | Received quadlet |
| q_last | input | 1 | Marks the final quadlet of a packet |
| status_clr | input | 2 | Write-one-to-clear for status bits |
| err_status | output | 2 | Sticky errors: bit 0 mismatch, bit 1 incomplete pair |
| irq | output | 1 | One-cycle error interrupt per failing packet |
| pair_cnt | output | CNT_W (8) | Completed pair count |

## Verification
The hardest cases to reach from the ports are the collisions. The first is an error and its clear landing in the same cycle. The second is a bus reset arriving while a first quadlet is latched and waiting for its partner. The bench drives the mismatching second quadlet and the clear write on the same edge, then checks that the bit survives. It also starts a pair, pulses `bus_rst` alongside a quadlet, and then sends a clean pair whose first half would mismatch the stale latch if the phase had not been reset.

// File: rtl/selfid_chk_pkg.sv
package selfid_chk_pkg;
  localparam int ERR_W   = 2;
  localparam int ERR_MIS = 0;
  localparam int ERR_ODD = 1;

  typedef struct packed {
    logic pair_done;
    logic mismatch;
    logic odd_end;
    logic pkt_end;
  } beat_ev_t;
endpackage

// File: rtl/selfid_pair_track.sv
module selfid_pair_track
  import selfid_chk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_rst,
  input  logic          q_valid,
  input  logic [DW-1:0] q_data,
  input  logic          q_last,
  output beat_ev_t      ev
);
  logic          phase;
  logic [DW-1:0] first_q;
  logic          vld;

  assign vld = q_valid && !bus_rst;

  always_ff @(posedge clk) begin
    if (rst || bus_rst) begin
      phase <= 1'b0;
    end else if (vld) begin
      phase <= q_last ? 1'b0 : !phase;
    end
    if (rst) begin
      first_q <= '0;
    end else if (vld && !phase) begin
      first_q <= q_data;
    end
  end

  always_comb begin
    ev.pair_done = vld && phase;
    ev.mismatch  = vld && phase && ((q_data ^ first_q) != {DW{1'b1}});
    ev.pkt_end   = vld && q_last;
    ev.odd_end   = vld && q_last && !phase;
  end

  p_restart_r5: assert property (@(posedge clk) disable iff (rst)
    (q_valid && q_last) |=> !phase);
  p_bus_rst_phase_r9: assert property (@(posedge clk) disable iff (rst)
    bus_rst |=> !phase);
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!q_valid && !bus_rst) |=> $stable(phase) && $stable(first_q));
endmodule

// File: rtl/selfid_err_status.sv
module selfid_err_status
  import selfid_chk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_rst,
  input  logic             chk_en,
  input  beat_ev_t         ev,
  input  logic [ERR_W-1:0] status_clr,
  output logic [ERR_W-1:0] status,
  output logic             irq
);
  logic [ERR_W-1:0] new_err;
  logic             pkt_acc;

  always_comb begin
    new_err          = '0;
    new_err[ERR_MIS] = chk_en && ev.mismatch;
    new_err[ERR_ODD] = chk_en && ev.odd_end;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status  <= '0;
      pkt_acc <= 1'b0;
      irq     <= 1'b0;
    end else begin
      status <= (status & ~status_clr) | new_err;
      irq    <= ev.pkt_end && chk_en && (pkt_acc || (|new_err));
      if (bus_rst || ev.pkt_end) begin
        pkt_acc <= 1'b0;
      end else if (|new_err) begin
        pkt_acc <= 1'b1;
      end
    end
  end

  p_irq_at_end_r6: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ev.pkt_end && chk_en));
  p_mis_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (chk_en && ev.mismatch) |=> status[ERR_MIS]);
  p_odd_sets_r5: assert property (@(posedge clk) disable iff (rst)
    (chk_en && ev.odd_end) |=> status[ERR_ODD]);
  p_sticky_mis_r7: assert property (@(posedge clk) disable iff (rst)
    (status[ERR_MIS] && !status_clr[ERR_MIS]) |=> status[ERR_MIS]);
  p_sticky_odd_r7: assert property (@(posedge clk) disable iff (rst)
    (status[ERR_ODD] && !status_clr[ERR_ODD]) |=> status[ERR_ODD]);
  p_quiet_off_r8: assert property (@(posedge clk) disable iff (rst)
    !chk_en |=> ((status & ~$past(status)) == '0) && !irq);
endmodule

// File: rtl/selfid_pair_counter.sv
module selfid_pair_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_rst,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || bus_rst) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end

  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    (inc && !bus_rst) |=> cnt == $past(cnt) + 1'b1);
  p_count_clear_r9: assert property (@(posedge clk) disable iff (rst)
    bus_rst |=> cnt == '0);
endmodule

// File: rtl/selfid_pair_chk.sv
module selfid_pair_chk
  import selfid_chk_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_rst,
  input  logic             chk_en,
  input  logic             q_valid,
  input  logic [DW-1:0]    q_data,
  input  logic             q_last,
  input  logic [ERR_W-1:0] status_clr,
  output logic [ERR_W-1:0] err_status,
  output logic             irq,
  output logic [CNT_W-1:0] pair_cnt
);
  beat_ev_t ev;

  selfid_pair_track #(.DW(DW)) u_track (
    .clk(clk), .rst(rst), .bus_rst(bus_rst), .q_valid(q_valid),
    .q_data(q_data), .q_last(q_last), .ev(ev)
  );

  selfid_err_status u_status (
    .clk(clk), .rst(rst), .bus_rst(bus_rst), .chk_en(chk_en), .ev(ev),
    .status_clr(status_clr), .status(err_status), .irq(irq)
  );

  selfid_pair_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .bus_rst(bus_rst), .inc(ev.pair_done), .cnt(pair_cnt)
  );

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (err_status == '0) && !irq && (pair_cnt == '0));
endmodule

// File: tb/selfid_pair_chk_tb_top.sv
module selfid_pair_chk_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rst = 1'b0;
  logic        chk_en = 1'b1;
  logic        q_valid = 1'b0;
  logic [31:0] q_data = '0;
  logic        q_last = 1'b0;
  logic [1:0]  status_clr = '0;
  logic [1:0]  err_status;
  logic        irq;
  logic [7:0]  pair_cnt;

  int total = 0;
  int bad   = 0;
  logic [7:0] exp_cnt = '0;
  logic seen_irq;

  always #4 clk = ~clk;

  selfid_pair_chk dut_i (
    .clk(clk), .rst(rst), .bus_rst(bus_rst), .chk_en(chk_en), .q_valid(q_valid),
    .q_data(q_data), .q_last(q_last), .status_clr(status_clr),
    .err_status(err_status), .irq(irq), .pair_cnt(pair_cnt)
  );

  // {en, expect_error, first, second}
  localparam logic [65:0] VEC [8] = '{
    {1'b1, 1'b0, 32'h12345678, 32'hEDCBA987},
    {1'b1, 1'b1, 32'h12345678, 32'hEDCBA986},
    {1'b1, 1'b0, 32'h00000000, 32'hFFFFFFFF},
    {1'b1, 1'b1, 32'h00000000, 32'h00000000},
    {1'b0, 1'b0, 32'h0F0F0F0F, 32'h0F0F0F0F},
    {1'b1, 1'b1, 32'h80000000, 32'hFFFFFFFF},
    {1'b1, 1'b0, 32'h80000000, 32'h7FFFFFFF},
    {1'b0, 1'b0, 32'hAAAAAAAA, 32'h55555555}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [31:0] d, input logic last);
    q_valid = 1'b1; q_data = d; q_last = last;
    @(negedge clk);
    q_valid = 1'b0; q_last = 1'b0;
    seen_irq = irq;
  endtask

  task automatic clear_all();
    status_clr = 2'b11;
    @(negedge clk);
    status_clr = 2'b00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 status", {30'd0, err_status}, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 count", {24'd0, pair_cnt}, 0);

    // table walk: R2 R3 R4 R8
    for (int k = 0; k < 8; k++) begin
      clear_all();
      chk_en = VEC[k][65];
      beat(VEC[k][63:32], 1'b0);
      beat(VEC[k][31:0], 1'b1);
      exp_cnt = exp_cnt + 1;
      check(VEC[k][64] ? "R3 mismatch bit" : "R4/R8 no error", {30'd0, err_status}, {31'd0, VEC[k][64]});
      check("R6 irq on failing packet", {31'd0, seen_irq}, {31'd0, VEC[k][64]});
      check("R2 pair count", {24'd0, pair_cnt}, {24'd0, exp_cnt});
      idle(1);
      check("R6 irq single cycle", {31'd0, irq}, 0);
    end
    chk_en = 1'b1;

    // R6: two mismatches in one packet, one pulse
    clear_all();
    beat(32'h1, 1'b0); beat(32'h1, 1'b0);
    check("R6 no irq mid packet", {31'd0, seen_irq}, 0);
    beat(32'h2, 1'b0); beat(32'h2, 1'b0);
    beat(32'h3, 1'b0); beat(~32'h3, 1'b1);
    exp_cnt = exp_cnt + 3;
    check("R6 one irq at end", {31'd0, seen_irq}, 1);
    idle(1);
    check("R6 pulse ends", {31'd0, irq}, 0);
    check("R3 mismatch kept", {30'd0, err_status}, 1);
    check("R2 count after three pairs", {24'd0, pair_cnt}, {24'd0, exp_cnt});

    // R5: odd packet then clean restart
    clear_all();
    beat(32'h10, 1'b0); beat(~32'h10, 1'b0); beat(32'h20, 1'b1);
    exp_cnt = exp_cnt + 1;
    check("R5 odd bit", {30'd0, err_status}, 2);
    check("R5 odd irq", {31'd0, seen_irq}, 1);
    clear_all();
    beat(32'h30, 1'b0); beat(~32'h30, 1'b1);
    exp_cnt = exp_cnt + 1;
    check("R5 restart clean", {30'd0, err_status}, 0);
    check("R5 restart no irq", {31'd0, seen_irq}, 0);

    // R10: idle gaps inside a pair
    beat(32'hCAFE0001, 1'b0); idle(3); beat(~32'hCAFE0001, 1'b1);
    exp_cnt = exp_cnt + 1;
    check("R10 gap no error", {30'd0, err_status}, 0);
    check("R10 gap count", {24'd0, pair_cnt}, {24'd0, exp_cnt});

    // R8: odd packet while disabled
    chk_en = 1'b0;
    beat(32'h44, 1'b1);
    check("R8 odd ignored", {30'd0, err_status}, 0);
    check("R8 no irq", {31'd0, seen_irq}, 0);
    chk_en = 1'b1;

    // R7: partial clear and set-over-clear
    beat(32'h5, 1'b1);
    beat(32'h6, 1'b0); beat(32'h6, 1'b1);
    exp_cnt = exp_cnt + 1;
    check("R7 both bits", {30'd0, err_status}, 3);
    status_clr = 2'b10;
    @(negedge clk);
    status_clr = 2'b00;
    check("R7 partial clear", {30'd0, err_status}, 1);
    beat(32'h7, 1'b0);
    status_clr = 2'b01;
    beat(32'h7, 1'b1);
    status_clr = 2'b00;
    exp_cnt = exp_cnt + 1;
    check("R7 set wins over clear", {30'd0, err_status}, 1);
    clear_all();
    check("R7 cleared", {30'd0, err_status}, 0);

    // R9: bus reset mid pair, status retained
    beat(32'h8, 1'b1);
    beat(32'h9, 1'b0);
    bus_rst = 1'b1;
    beat(32'hDEAD0000, 1'b0);
    bus_rst = 1'b0;
    exp_cnt = '0;
    check("R9 count cleared", {24'd0, pair_cnt}, 0);
    check("R9 status kept", {30'd0, err_status}, 2);
    beat(32'h0000BEEF, 1'b0); beat(~32'h0000BEEF, 1'b1);
    exp_cnt = exp_cnt + 1;
    check("R9 fresh pair clean", {30'd0, err_status}, 2);
    check("R9 fresh pair no irq", {31'd0, seen_irq}, 0);
    check("R9 count restarts", {24'd0, pair_cnt}, {24'd0, exp_cnt});

    // R2: count wraps
    for (int i = 0; i < 255; i++) begin
      beat(i, 1'b0); beat(~i, 1'b0);
    end
    check("R2 count wraps", {24'd0, pair_cnt}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule